// File: doc/BRIEF.md
# Task-Based Paged Memory Mapper

This block sits between a CPU with a 16-bit address bus and a larger physical memory. It splits the CPU space into eight 8 KB pages. For each access it looks up a 16-bit mapping entry for the page, joins the entry's physical page number to the low 13 address bits and drives a 26-bit physical address. An entry set is chosen by a 5-bit task number together with the low bits of a secondary-task number. Switching the task register therefore switches the whole address map at once.

Every entry carries three protection flags: write-protect, valid and no-execute. The block checks these on each access. It raises a separate fault flag for each violation and withholds the memory enable and write strobe. Two regions skip the per-task lookup. The first is a 16-byte register window at a fixed CPU address, through which software programs the mapper. The second is an optional shared area in the top 8 KB, which goes to one physical page held in a dedicated register. After reset, set 0 holds an identity map, so the CPU can boot without any setup.

Top module: `mmu_task_mapper`

## Requirements
- R1: After reset the task, secondary-task, control, index and common-page registers are zero. Set (task 0, secondary 0) maps CPU page n to physical page n with only the valid flag set. Every entry of every other set is zero, which makes it invalid.
- R2: For an access outside the window and the common area, the entry is selected by cpu_addr[15:13]. phys_addr is {entry bits 12:0, cpu_addr[12:0]} in the same cycle. mem_en is high when no fault is raised, and mem_we equals mem_en && cpu_we.
- R3: Window offset 0 holds the 5-bit task number, and a read returns it zero-extended. Each task selects its own independent entries.
- R4: Window offset 1 holds a 7-bit secondary-task number that reads back in full. Its low SUB_SEL_W bits (default 1) combine with the task number to select the entry set; the bits above them do not affect the selection.
- R5: Entry bit 15 is write-protect. A write to such a page sets flt_wp and holds mem_en and mem_we low. A read of the same page is unaffected.
- R6: Entry bit 14 is valid. Any access to a page whose valid bit is clear sets flt_inv and holds mem_en low.
- R7: Entry bit 13 is no-execute. A fetch (cpu_fetch high) from such a page sets flt_nx and holds mem_en low. A non-fetch read of the page is unaffected.
- R8: Window offset 3 selects the entry index (3 bits). A write to offset 4 only stages a low byte and leaves the entry unchanged. A write to offset 5 stores {written byte, staged byte} into the selected entry of the active set at that clock edge. Reads of offsets 4 and 5 return the entry's current low and high bytes.
- R9: Bit 0 of window offset 2 enables the common area. The common page is 13 bits: offset 6 holds bits 7:0 and offset 7 holds bits 12:8 in its low 5 bits. When the common area is enabled, addresses with cpu_addr[15:13] = 7 go to the common page with no fault, whatever the task and its entries.
- R10: The window is 0xFE00 to 0xFE0F. It is decoded ahead of translation in every task, raises io_hit, never raises mem_en or a fault, and returns register data on reads. Offsets 8 to 15 read as zero, and writes to them change nothing.
- R11: Registers change only at a clock edge where cpu_req and cpu_we are both high. cpu_rdata is zero outside window reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Bus cycle valid |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | Write cycle |
| cpu_fetch | input | 1 | Opcode fetch cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read data |
| phys_addr | output | 26 | Translated physical address |
| mem_en | output | 1 | Memory access permitted |
| mem_we | output | 1 | Memory write strobe |
| io_hit | output | 1 | Access falls in the register window |
| flt_wp | output | 1 | Write-protect fault |
| flt_inv | output | 1 | Invalid-entry fault |
| flt_nx | output | 1 | Execute fault |

## Verification
The assertions check on every cycle that translated accesses keep their page offset, that window accesses never reach memory or raise a fault, that a write-protect fault always suppresses the strobe, that an enabled common area overrides translation, and that a task write and a high-byte commit land at the next edge. The directed scenarios are needed to show the rest. They show the reset identity map and that tasks and secondary sets are isolated from each other. They also show that a low-byte write alone leaves the entry unchanged, that unused window offsets ignore writes, and that the common area behaves the same in a task whose entries are all invalid.

// File: rtl/mmu_task_mapper_pkg.sv
package mmu_task_mapper_pkg;
    localparam int CPU_AW   = 16;
    localparam int PG_OFS_W = 13;
    localparam int IDX_W    = CPU_AW - PG_OFS_W;
    localparam int N_IDX    = 1 << IDX_W;
    localparam int PPN_W    = 13;
    localparam int PA_W     = PPN_W + PG_OFS_W;
    localparam int TASK_W   = 5;
    localparam int SUB_W    = 7;
    localparam int DATA_W   = 8;
    localparam int WIN_W    = 4;

    typedef struct packed {
        logic             wp;
        logic             vld;
        logic             nx;
        logic [PPN_W-1:0] ppn;
    } map_ent_t;

    typedef enum logic [WIN_W-1:0] {
        REG_TASK   = 4'd0,
        REG_SUB    = 4'd1,
        REG_CTRL   = 4'd2,
        REG_IDX    = 4'd3,
        REG_ENT_LO = 4'd4,
        REG_ENT_HI = 4'd5,
        REG_CPG_LO = 4'd6,
        REG_CPG_HI = 4'd7
    } reg_ofs_e;
endpackage

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_task_mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_wr_i,
    input  logic [WIN_W-1:0]     ofs_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  map_ent_t             ent_rd_i,
    output logic [TASK_W-1:0]    task_o,
    output logic [SUB_W-1:0]     sub_o,
    output logic                 cmn_en_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [PPN_W-1:0]     cpg_o,
    output logic                 ent_we_o,
    output map_ent_t             ent_wdata_o,
    output logic [DATA_W-1:0]    rdata_o
);
    localparam int CPG_HI_W = PPN_W - DATA_W;

    typedef struct packed {
        logic [TASK_W-1:0] task_no;
        logic [SUB_W-1:0]  sub_no;
        logic              cmn_en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] stage_lo;
        logic [PPN_W-1:0]  cpg;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic      ent_we_d;

    always_comb begin
        r_d      = r_q;
        ent_we_d = 1'b0;
        if (acc_wr_i) begin
            case (ofs_i)
                REG_TASK:   r_d.task_no  = wdata_i[TASK_W-1:0];
                REG_SUB:    r_d.sub_no   = wdata_i[SUB_W-1:0];
                REG_CTRL:   r_d.cmn_en   = wdata_i[0];
                REG_IDX:    r_d.idx      = wdata_i[IDX_W-1:0];
                REG_ENT_LO: r_d.stage_lo = wdata_i;
                REG_ENT_HI: ent_we_d     = 1'b1;
                REG_CPG_LO: r_d.cpg[DATA_W-1:0] = wdata_i;
                REG_CPG_HI: r_d.cpg[PPN_W-1:DATA_W] = wdata_i[CPG_HI_W-1:0];
                default:    r_d = r_q;
            endcase
        end
    end

    always_comb begin
        case (ofs_i)
            REG_TASK:   rdata_o = DATA_W'(r_q.task_no);
            REG_SUB:    rdata_o = DATA_W'(r_q.sub_no);
            REG_CTRL:   rdata_o = DATA_W'(r_q.cmn_en);
            REG_IDX:    rdata_o = DATA_W'(r_q.idx);
            REG_ENT_LO: rdata_o = ent_rd_i[DATA_W-1:0];
            REG_ENT_HI: rdata_o = ent_rd_i[2*DATA_W-1:DATA_W];
            REG_CPG_LO: rdata_o = r_q.cpg[DATA_W-1:0];
            REG_CPG_HI: rdata_o = DATA_W'(r_q.cpg[PPN_W-1:DATA_W]);
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign task_o      = r_q.task_no;
    assign sub_o       = r_q.sub_no;
    assign cmn_en_o    = r_q.cmn_en;
    assign idx_o       = r_q.idx;
    assign cpg_o       = r_q.cpg;
    assign ent_we_o    = ent_we_d;
    assign ent_wdata_o = map_ent_t'({wdata_i, r_q.stage_lo});

    // R3: a task write is visible after the edge
    a_r3_task_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_i && ofs_i == REG_TASK) |=> (task_o == $past(wdata_i[TASK_W-1:0])));
    // R8: a low-byte write leaves the entry strobe idle
    a_r8_lo_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_i && ofs_i == REG_ENT_LO) |-> !ent_we_o);
endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table
    import mmu_task_mapper_pkg::*;
#(
    parameter int SET_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [IDX_W-1:0] xl_idx_i,
    input  logic [IDX_W-1:0] rg_idx_i,
    input  logic             we_i,
    input  map_ent_t         wdata_i,
    output map_ent_t         xl_ent_o,
    output map_ent_t         rg_ent_o
);
    localparam int NSETS = 1 << SET_W;

    map_ent_t tbl_d [NSETS-1:0][N_IDX-1:0];
    map_ent_t tbl_q [NSETS-1:0][N_IDX-1:0];

    always_comb begin
        tbl_d = tbl_q;
        if (we_i) tbl_d[set_i][rg_idx_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int e = 0; e < N_IDX; e++) begin
                    tbl_q[s][e] <= '0;
                end
            end
            for (int e = 0; e < N_IDX; e++) begin
                tbl_q[0][e] <= '{wp: 1'b0, vld: 1'b1, nx: 1'b0, ppn: PPN_W'(e)};
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign xl_ent_o = tbl_q[set_i][xl_idx_i];
    assign rg_ent_o = tbl_q[set_i][rg_idx_i];

    // R8: a committed entry holds the written value after the edge
    a_r8_entry_commit: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (tbl_q[$past(set_i)][$past(rg_idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_task_mapper_pkg::*;
#(
    parameter logic [CPU_AW-1:0] IO_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [CPU_AW-1:0] addr_i,
    input  logic              we_i,
    input  logic              fetch_i,
    input  map_ent_t          ent_i,
    input  logic              cmn_en_i,
    input  logic [PPN_W-1:0]  cpg_i,
    output logic [PA_W-1:0]   pa_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic              io_hit_o,
    output logic              f_wp_o,
    output logic              f_inv_o,
    output logic              f_nx_o
);
    localparam logic [IDX_W-1:0] CMN_IDX = IDX_W'(N_IDX - 1);

    logic             in_cmn;
    logic             chk;
    logic [PPN_W-1:0] ppn;

    always_comb begin
        io_hit_o = req_i && (addr_i[CPU_AW-1:WIN_W] == IO_BASE[CPU_AW-1:WIN_W]);
        in_cmn   = cmn_en_i && (addr_i[CPU_AW-1:PG_OFS_W] == CMN_IDX);
        ppn      = in_cmn ? cpg_i : ent_i.ppn;
        pa_o     = {ppn, addr_i[PG_OFS_W-1:0]};
        chk      = req_i && !io_hit_o && !in_cmn;
        f_inv_o  = chk && !ent_i.vld;
        f_wp_o   = chk && we_i && ent_i.wp;
        f_nx_o   = chk && fetch_i && ent_i.nx;
        mem_en_o = req_i && !io_hit_o && !(f_inv_o || f_wp_o || f_nx_o);
        mem_we_o = mem_en_o && we_i;
    end

    // R2: memory accesses keep the page offset
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> (pa_o[PG_OFS_W-1:0] == addr_i[PG_OFS_W-1:0]));
    // R10: window accesses never reach memory nor fault
    a_r10_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit_o |-> !(mem_en_o || f_wp_o || f_inv_o || f_nx_o));
    // R5: a protected write never strobes memory
    a_r5_wp_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        f_wp_o |-> (!mem_we_o && !mem_en_o));
    // R9: enabled common area overrides the entry
    a_r9_common_route: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cmn_en_i && !io_hit_o && addr_i[CPU_AW-1:PG_OFS_W] == CMN_IDX)
        |-> (mem_en_o && pa_o[PA_W-1:PG_OFS_W] == cpg_i));
endmodule

// File: rtl/mmu_task_mapper.sv
module mmu_task_mapper
    import mmu_task_mapper_pkg::*;
#(
    parameter int                SUB_SEL_W = 1,
    parameter logic [CPU_AW-1:0] IO_BASE   = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_fetch,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [PA_W-1:0]   phys_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic              io_hit,
    output logic              flt_wp,
    output logic              flt_inv,
    output logic              flt_nx
);
    localparam int SET_W = TASK_W + SUB_SEL_W;

    logic [TASK_W-1:0] task_no;
    logic [SUB_W-1:0]  sub_no;
    logic              cmn_en;
    logic [IDX_W-1:0]  idx;
    logic [PPN_W-1:0]  cpg;
    logic              ent_we;
    map_ent_t          ent_wdata;
    map_ent_t          xl_ent;
    map_ent_t          rg_ent;
    logic [DATA_W-1:0] rg_rdata;
    logic [SET_W-1:0]  set_sel;

    assign set_sel = {sub_no[SUB_SEL_W-1:0], task_no};

    mmu_ctl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_wr_i   (io_hit && cpu_we),
        .ofs_i      (cpu_addr[WIN_W-1:0]),
        .wdata_i    (cpu_wdata),
        .ent_rd_i   (rg_ent),
        .task_o     (task_no),
        .sub_o      (sub_no),
        .cmn_en_o   (cmn_en),
        .idx_o      (idx),
        .cpg_o      (cpg),
        .ent_we_o   (ent_we),
        .ent_wdata_o(ent_wdata),
        .rdata_o    (rg_rdata)
    );

    mmu_page_table #(.SET_W(SET_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_sel),
        .xl_idx_i (cpu_addr[CPU_AW-1:PG_OFS_W]),
        .rg_idx_i (idx),
        .we_i     (ent_we),
        .wdata_i  (ent_wdata),
        .xl_ent_o (xl_ent),
        .rg_ent_o (rg_ent)
    );

    mmu_xlate #(.IO_BASE(IO_BASE)) u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (cpu_req),
        .addr_i   (cpu_addr),
        .we_i     (cpu_we),
        .fetch_i  (cpu_fetch),
        .ent_i    (xl_ent),
        .cmn_en_i (cmn_en),
        .cpg_i    (cpg),
        .pa_o     (phys_addr),
        .mem_en_o (mem_en),
        .mem_we_o (mem_we),
        .io_hit_o (io_hit),
        .f_wp_o   (flt_wp),
        .f_inv_o  (flt_inv),
        .f_nx_o   (flt_nx)
    );

    assign cpu_rdata = (io_hit && !cpu_we) ? rg_rdata : '0;

    // R11: nothing but a window read drives read data
    a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> (cpu_rdata == '0));
endmodule

// File: tb/tb_mmu_task_mapper.sv
module tb_mmu_task_mapper;
    localparam int CLK_P = 10;
    localparam logic [15:0] IOB = 16'hFE00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_fetch = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [25:0] phys_addr;
    logic        mem_en, mem_we, io_hit, flt_wp, flt_inv, flt_nx;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    mmu_task_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_fetch(cpu_fetch), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .phys_addr(phys_addr), .mem_en(mem_en),
        .mem_we(mem_we), .io_hit(io_hit), .flt_wp(flt_wp), .flt_inv(flt_inv),
        .flt_nx(flt_nx)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] pa_of(input logic [12:0] ppn, input logic [15:0] a);
        return {ppn, a[12:0]};
    endfunction

    task automatic idle();
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_fetch = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_req = 1'b1; cpu_fetch = 1'b0;
        @(posedge clk);
        #1 idle();
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_we = 1'b0; cpu_fetch = 1'b0; cpu_req = 1'b1;
        #1 d = cpu_rdata;
        idle();
    endtask

    // drive an access and leave outputs settled for sampling; caller idles
    task automatic acc(input logic [15:0] a, input logic w, input logic f);
        @(negedge clk);
        cpu_addr = a; cpu_we = w; cpu_fetch = f; cpu_req = 1'b1; cpu_wdata = 8'h00;
        #1;
    endtask

    task automatic set_ent(input logic [2:0] i, input logic wp, input logic v,
                           input logic nx, input logic [12:0] ppn);
        wr(IOB + 16'd3, {5'd0, i});
        wr(IOB + 16'd4, ppn[7:0]);
        wr(IOB + 16'd5, {wp, v, nx, ppn[12:8]});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(IOB + 16'd0, d); chk(d, 8'h00, "R1 task reg");
        rd(IOB + 16'd1, d); chk(d, 8'h00, "R1 sub reg");
        rd(IOB + 16'd2, d); chk(d, 8'h00, "R1 ctrl reg");
        rd(IOB + 16'd6, d); chk(d, 8'h00, "R1 common page lo");
        rd(IOB + 16'd5, d); chk(d, 8'h40, "R1 entry0 hi byte valid only");
        rd(IOB + 16'd4, d); chk(d, 8'h00, "R1 entry0 lo byte");
        acc(16'h2345, 1'b0, 1'b0);
        chk(phys_addr, 26'h2345, "R1 identity map");
        chk({mem_en, flt_wp, flt_inv, flt_nx}, 4'b1000, "R1 no faults at boot");
        idle();
        acc(16'h5ABC, 1'b1, 1'b0);
        chk({mem_en, mem_we}, 2'b11, "R2 write strobe");
        chk(phys_addr, 26'h5ABC, "R2 write address");
        idle();
    endtask

    task automatic t_entry();
        logic [7:0] d;
        wr(IOB + 16'd3, 8'd2);
        wr(IOB + 16'd4, 8'hBC);
        acc(16'h4123, 1'b0, 1'b0);
        chk(phys_addr, 26'h4123, "R8 low byte alone leaves entry");
        idle();
        wr(IOB + 16'd5, 8'h5A);
        acc(16'h4123, 1'b0, 1'b0);
        chk(phys_addr, pa_of(13'h1ABC, 16'h4123), "R2 remapped page");
        chk(mem_en, 1'b1, "R2 mem_en");
        idle();
        rd(IOB + 16'd4, d); chk(d, 8'hBC, "R8 read lo");
        rd(IOB + 16'd5, d); chk(d, 8'h5A, "R8 read hi");
        set_ent(3'd2, 1'b0, 1'b1, 1'b0, 13'd2);
    endtask

    task automatic t_tasks();
        logic [7:0] d;
        wr(IOB + 16'd0, 8'd5);
        rd(IOB + 16'd0, d); chk(d, 8'd5, "R3 task readback");
        acc(16'h0010, 1'b0, 1'b0);
        chk({mem_en, flt_inv}, 2'b01, "R3 new task starts invalid");
        idle();
        set_ent(3'd0, 1'b0, 1'b1, 1'b0, 13'h0100);
        acc(16'h0010, 1'b0, 1'b0);
        chk(phys_addr, pa_of(13'h0100, 16'h0010), "R3 task5 mapping");
        idle();
        wr(IOB + 16'd0, 8'd0);
        acc(16'h0010, 1'b0, 1'b0);
        chk(phys_addr, 26'h0010, "R3 task0 untouched");
        idle();
        wr(IOB + 16'd0, 8'hFF);
        rd(IOB + 16'd0, d); chk(d, 8'h1F, "R3 five bit task");
        wr(IOB + 16'd0, 8'd0);
    endtask

    task automatic t_sub();
        logic [7:0] d;
        wr(IOB + 16'd1, 8'd1);
        acc(16'h0010, 1'b0, 1'b0);
        chk(flt_inv, 1'b1, "R4 secondary set starts invalid");
        idle();
        set_ent(3'd0, 1'b0, 1'b1, 1'b0, 13'h0777);
        acc(16'h0010, 1'b0, 1'b0);
        chk(phys_addr, pa_of(13'h0777, 16'h0010), "R4 secondary mapping");
        idle();
        wr(IOB + 16'd1, 8'h7E);
        rd(IOB + 16'd1, d); chk(d, 8'h7E, "R4 seven bit readback");
        acc(16'h0010, 1'b0, 1'b0);
        chk(phys_addr, 26'h0010, "R4 upper bits do not select");
        idle();
        wr(IOB + 16'd1, 8'h00);
    endtask

    task automatic t_prot();
        set_ent(3'd3, 1'b1, 1'b1, 1'b0, 13'd3);
        acc(16'h6000, 1'b1, 1'b0);
        chk({flt_wp, mem_en, mem_we}, 3'b100, "R5 protected write");
        idle();
        acc(16'h6000, 1'b0, 1'b0);
        chk({flt_wp, mem_en}, 2'b01, "R5 protected read ok");
        idle();
        set_ent(3'd4, 1'b0, 1'b1, 1'b1, 13'd4);
        acc(16'h8000, 1'b0, 1'b1);
        chk({flt_nx, mem_en}, 2'b10, "R7 fetch from no-exec");
        idle();
        acc(16'h8000, 1'b0, 1'b0);
        chk({flt_nx, mem_en}, 2'b01, "R7 data read ok");
        idle();
        set_ent(3'd5, 1'b0, 1'b0, 1'b0, 13'd5);
        acc(16'hA000, 1'b0, 1'b0);
        chk({flt_inv, mem_en}, 2'b10, "R6 invalid entry");
        idle();
        acc(16'hA000, 1'b1, 1'b0);
        chk({flt_inv, mem_we}, 2'b10, "R6 invalid write");
        idle();
    endtask

    task automatic t_common();
        logic [7:0] d;
        wr(IOB + 16'd6, 8'h34);
        wr(IOB + 16'd7, 8'hF2);
        rd(IOB + 16'd7, d); chk(d, 8'h12, "R9 common hi five bits");
        acc(16'hE100, 1'b0, 1'b0);
        chk(phys_addr, 26'hE100, "R9 disabled uses entry");
        idle();
        wr(IOB + 16'd2, 8'h01);
        acc(16'hE100, 1'b0, 1'b0);
        chk(phys_addr, pa_of(13'h1234, 16'hE100), "R9 common page");
        idle();
        wr(IOB + 16'd0, 8'd5);
        acc(16'hE100, 1'b1, 1'b0);
        chk({mem_en, mem_we, flt_inv}, 3'b110, "R9 common in invalid task");
        chk(phys_addr, pa_of(13'h1234, 16'hE100), "R9 common address task5");
        idle();
        wr(IOB + 16'd2, 8'h00);
        acc(16'hE100, 1'b0, 1'b0);
        chk(flt_inv, 1'b1, "R9 disabled falls to entry");
        idle();
    endtask

    task automatic t_io();
        logic [7:0] d;
        acc(IOB + 16'd0, 1'b0, 1'b0);
        chk({io_hit, mem_en, flt_inv}, 3'b100, "R10 window in invalid task");
        chk(cpu_rdata, 8'd5, "R10 window read");
        idle();
        acc(IOB + 16'd9, 1'b1, 1'b0);
        chk({io_hit, mem_we}, 2'b10, "R10 window write no strobe");
        idle();
        wr(IOB + 16'hA, 8'h55);
        rd(IOB + 16'hA, d); chk(d, 8'h00, "R10 unused offset reads zero");
        rd(IOB + 16'd0, d); chk(d, 8'd5, "R10 unused write ignored");
        acc(16'h0010, 1'b0, 1'b0);
        chk(cpu_rdata, 8'h00, "R11 rdata zero outside window");
        idle();
        @(negedge clk);
        cpu_addr = IOB; cpu_wdata = 8'd9; cpu_we = 1'b1; cpu_req = 1'b0;
        @(posedge clk);
        #1 idle();
        rd(IOB + 16'd0, d); chk(d, 8'd5, "R11 no write without req");
        wr(IOB + 16'd0, 8'd0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_entry();
        t_tasks();
        t_sub();
        t_prot();
        t_common();
        t_io();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule